// File: doc/BRIEF.md
# Core Power Domain Sequencer

This block is a hardware state machine that powers a processor core's domain on and off. It drives each power, clamp, clock and reset control in a fixed order, so that no control changes before the one it depends on. A pulse on `up_req` starts the power-on walk and a pulse on `down_req` starts the power-off walk. While a walk runs, the block ignores both request inputs.

Two steps wait on status from the analog side. During power-on the block waits for the reference clock's off flag to drop. During power-off it waits for the head switch's acknowledge to clear. Each wait samples its status input once every `POLL_GAP` cycles and gives up after `POLL_MAX` samples. When a wait gives up, the block raises `fault`, leaves every control at its current value and returns to idle.

All delays are counted in clock cycles. The default parameters derive them from `CLK_MHZ`. The memory banks are switched one at a time: they turn on from the highest bank down to bank 0, and they turn off from bank 0 up to the highest bank. Each bank step is followed by a wait.

Top module: `core_pwr_seq`

## Requirements
- R1: While reset is held and right after it, the outputs are: `dom_rst`, `core_rst`, `bus_rst`, `core_hold`, `mem_clamp`, `wl_clamp` and `io_clamp` at 1, and every other output at 0. `bank_on` is all zeros.
- R2: An accepted `up_req` clears `finished` and `fault` on the accepting edge. On the next edge, `core_rst`, `bus_rst` and `core_hold` are set, `ref_clk_en` is set and `dom_rst` is cleared, all on that same edge.
- R3: After `ref_clk_en` is set, `clk_off` is sampled on the edges POLL_GAP, 2*POLL_GAP, ... up to POLL_MAX*POLL_GAP cycles later. On the first sample that reads 0, `hs_on` is set on that same edge. If every sample up to the last one reads 1, `fault` is set on that edge, all other outputs keep their values and the block goes idle.
- R4: `ldo_bypass` is set exactly SETTLE_CYC cycles after `hs_on` rises.
- R5: One cycle after the bypass, `mem_clamp` clears. One cycle after that, `stby_n` and `ret_n` are both set on the same edge.
- R6: Starting one cycle after `ret_n`, bank bits are set one at a time, highest index first, every SETTLE_CYC cycles. Bits already set stay set.
- R7: SETTLE_CYC cycles after bank 0 is set, `wl_clamp` clears. Then, one cycle apart, `io_clamp` clears, `core_rst` clears and `core_clk_en` sets. Finally `core_hold` clears and `finished` sets on the same edge.
- R8: An accepted `down_req` clears `finished` and `fault`. Then, on four consecutive edges in this order: `core_clk_en` clears, `io_clamp` sets, `stby_n` clears and `ret_n` clears.
- R9: Starting one cycle after `ret_n` clears, bank bits are cleared one at a time, bank 0 first, every BANK_OFF_CYC cycles.
- R10: BANK_OFF_CYC cycles after the last bank clears, `mem_clamp` sets. One cycle later, `hs_on` clears. `hs_ack` is then polled by the same rule as R3, counted from the fall of `hs_on`. On success, `dom_rst` and `core_rst` set together with `finished`. On a timeout, `fault` sets and all other outputs hold.
- R11: While a walk is in progress, `up_req` and `down_req` have no effect. In idle, when both requests are high together, `up_req` wins. Outputs do not change while the block is idle with no request.
- R12: `finished` and `fault` are never high at the same time. Each holds its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Start the power-on walk (taken only in idle) |
| down_req | input | 1 | Start the power-off walk (taken only in idle) |
| clk_off | input | 1 | 1 while the reference clock has not started |
| hs_ack | input | 1 | 1 while the head switch has not finished turning off |
| finished | output | 1 | Last walk completed |
| fault | output | 1 | Last walk timed out on a status wait |
| dom_rst | output | 1 | Subsystem (domain) reset |
| core_rst | output | 1 | Core reset |
| bus_rst | output | 1 | Core bus reset |
| core_hold | output | 1 | Core stop (hold execution) |
| ref_clk_en | output | 1 | Reference clock enable |
| hs_on | output | 1 | Power head switch on |
| ldo_bypass | output | 1 | Regulator bypass |
| mem_clamp | output | 1 | Memory clamp |
| wl_clamp | output | 1 | Word-line clamp |
| io_clamp | output | 1 | IO clamp |
| ret_n | output | 1 | Retention not-asserted |
| stby_n | output | 1 | Standby not-asserted |
| core_clk_en | output | 1 | Core clock enable |
| bank_on | output | NBANKS | Per-bank memory power enables |

## Verification
The assertions check the local ordering rules on every cycle:
- a bank bit changes at most once per cycle;
- banks are added only with retention on and the memory clamp off;
- banks are removed only with the IO clamp on and the core clock off;
- the head switch rises only after a low clock-off sample;
- the domain reset rises only after a clear acknowledge;
- the core leaves its hold only once its clock runs and its clamps are off.

Only the bench scenarios can show the exact cycle of each step. The same applies to the poll-count limit at its boundary, to which bank moves in which order, to outputs freezing on a timeout, and to requests being ignored mid-walk.

// File: rtl/core_pwr_seq.sv
module core_pwr_seq #(
  parameter int CLK_MHZ      = 200,
  parameter int NBANKS       = 20,
  parameter int SETTLE_CYC   = CLK_MHZ,
  parameter int BANK_OFF_CYC = CLK_MHZ * 1000,
  parameter int POLL_GAP     = CLK_MHZ,
  parameter int POLL_MAX     = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic              down_req,
  input  logic              clk_off,
  input  logic              hs_ack,
  output logic              finished,
  output logic              fault,
  output logic              dom_rst,
  output logic              core_rst,
  output logic              bus_rst,
  output logic              core_hold,
  output logic              ref_clk_en,
  output logic              hs_on,
  output logic              ldo_bypass,
  output logic              mem_clamp,
  output logic              wl_clamp,
  output logic              io_clamp,
  output logic              ret_n,
  output logic              stby_n,
  output logic              core_clk_en,
  output logic [NBANKS-1:0] bank_on
);

  localparam int MAXW = (SETTLE_CYC > BANK_OFF_CYC) ?
                        ((SETTLE_CYC > POLL_GAP) ? SETTLE_CYC : POLL_GAP) :
                        ((BANK_OFF_CYC > POLL_GAP) ? BANK_OFF_CYC : POLL_GAP);
  localparam int CW = $clog2(MAXW + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int IW = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  typedef enum logic [4:0] {
    IDLE, U_RST, U_POLL, U_SETTLE, U_MEM, U_RET, U_BANK, U_WL, U_IO, U_CRST,
    U_CCLK, U_GO, D_CLK, D_IO, D_STBY, D_RET, D_BANK, D_MEM, D_HS, D_POLL
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] polls;
  logic [IW-1:0] idx;

  wire gap_hit    = (cnt == CW'(POLL_GAP - 1));
  wire settle_hit = (cnt == CW'(SETTLE_CYC - 1));
  wire off_hit    = (cnt == CW'(BANK_OFF_CYC - 1));
  wire last_poll  = (polls == PW'(POLL_MAX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; polls <= '0; idx <= '0;
      finished <= 1'b0; fault <= 1'b0;
      dom_rst <= 1'b1; core_rst <= 1'b1; bus_rst <= 1'b1; core_hold <= 1'b1;
      ref_clk_en <= 1'b0; hs_on <= 1'b0; ldo_bypass <= 1'b0;
      mem_clamp <= 1'b1; wl_clamp <= 1'b1; io_clamp <= 1'b1;
      ret_n <= 1'b0; stby_n <= 1'b0; core_clk_en <= 1'b0; bank_on <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (up_req) begin
            st <= U_RST; finished <= 1'b0; fault <= 1'b0;
          end else if (down_req) begin
            st <= D_CLK; finished <= 1'b0; fault <= 1'b0;
          end
        end
        U_RST: begin
          core_rst <= 1'b1; bus_rst <= 1'b1; core_hold <= 1'b1;
          dom_rst <= 1'b0; ref_clk_en <= 1'b1;
          cnt <= '0; polls <= '0; st <= U_POLL;
        end
        U_POLL: begin
          if (gap_hit) begin
            cnt <= '0;
            if (!clk_off) begin
              hs_on <= 1'b1; st <= U_SETTLE;
            end else if (last_poll) begin
              fault <= 1'b1; st <= IDLE;
            end else polls <= polls + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        U_SETTLE: begin
          if (settle_hit) begin
            ldo_bypass <= 1'b1; cnt <= '0; st <= U_MEM;
          end else cnt <= cnt + 1'b1;
        end
        U_MEM: begin mem_clamp <= 1'b0; st <= U_RET; end
        U_RET: begin
          stby_n <= 1'b1; ret_n <= 1'b1;
          idx <= IW'(NBANKS - 1); cnt <= '0; st <= U_BANK;
        end
        U_BANK: begin
          if (cnt == '0) bank_on[idx] <= 1'b1;
          if (settle_hit) begin
            cnt <= '0;
            if (idx == '0) st <= U_WL;
            else idx <= idx - 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        U_WL:   begin wl_clamp <= 1'b0; st <= U_IO; end
        U_IO:   begin io_clamp <= 1'b0; st <= U_CRST; end
        U_CRST: begin core_rst <= 1'b0; st <= U_CCLK; end
        U_CCLK: begin core_clk_en <= 1'b1; st <= U_GO; end
        U_GO:   begin core_hold <= 1'b0; finished <= 1'b1; st <= IDLE; end
        D_CLK:  begin core_clk_en <= 1'b0; st <= D_IO; end
        D_IO:   begin io_clamp <= 1'b1; st <= D_STBY; end
        D_STBY: begin stby_n <= 1'b0; st <= D_RET; end
        D_RET:  begin ret_n <= 1'b0; idx <= '0; cnt <= '0; st <= D_BANK; end
        D_BANK: begin
          if (cnt == '0) bank_on[idx] <= 1'b0;
          if (off_hit) begin
            cnt <= '0;
            if (idx == IW'(NBANKS - 1)) st <= D_MEM;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        D_MEM: begin mem_clamp <= 1'b1; st <= D_HS; end
        D_HS:  begin hs_on <= 1'b0; cnt <= '0; polls <= '0; st <= D_POLL; end
        D_POLL: begin
          if (gap_hit) begin
            cnt <= '0;
            if (!hs_ack) begin
              dom_rst <= 1'b1; core_rst <= 1'b1; finished <= 1'b1; st <= IDLE;
            end else if (last_poll) begin
              fault <= 1'b1; st <= IDLE;
            end else polls <= polls + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R6
  bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_on ^ $past(bank_on)) <= 1);

  // R6
  bank_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bank_on) > $countones($past(bank_on))) |->
      (ret_n && stby_n && !mem_clamp && hs_on));

  // R9
  bank_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bank_on) < $countones($past(bank_on))) |->
      (!ret_n && !stby_n && io_clamp && !core_clk_en));

  // R3
  hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> ($past(!clk_off) && ref_clk_en));

  // R4
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldo_bypass) |-> hs_on);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> (core_clk_en && !core_rst && !io_clamp && !wl_clamp));

  // R10
  dom_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst) |-> ($past(!hs_ack) && !hs_on && mem_clamp));

  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(finished && fault));

endmodule

// File: tb/test_core_pwr_seq.sv
module test_core_pwr_seq;
  localparam int S  = 3;
  localparam int B  = 4;
  localparam int G  = 2;
  localparam int PM = 3;
  localparam int NB = 20;
  localparam int VW = NB + 15;
  localparam int CCLK = NB, STBY = NB+1, RET = NB+2, IOC = NB+3, WLC = NB+4,
                 MCL = NB+5, BYP = NB+6, HS = NB+7, REF = NB+8, HOLD = NB+9,
                 BRST = NB+10, CRST = NB+11, DRST = NB+12, FIN = NB+13, FLT = NB+14;

  logic clk = 1'b0, rst_n = 1'b0, up_req = 1'b0, down_req = 1'b0;
  logic clk_off = 1'b1, hs_ack = 1'b1;
  logic finished, fault, dom_rst, core_rst, bus_rst, core_hold, ref_clk_en, hs_on;
  logic ldo_bypass, mem_clamp, wl_clamp, io_clamp, ret_n, stby_n, core_clk_en;
  logic [NB-1:0] bank_on;
  int checks = 0, fails = 0, cyc = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  core_pwr_seq #(.NBANKS(NB), .SETTLE_CYC(S), .BANK_OFF_CYC(B),
                 .POLL_GAP(G), .POLL_MAX(PM)) i_core_pwr_seq (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
    .clk_off(clk_off), .hs_ack(hs_ack), .finished(finished), .fault(fault),
    .dom_rst(dom_rst), .core_rst(core_rst), .bus_rst(bus_rst),
    .core_hold(core_hold), .ref_clk_en(ref_clk_en), .hs_on(hs_on),
    .ldo_bypass(ldo_bypass), .mem_clamp(mem_clamp), .wl_clamp(wl_clamp),
    .io_clamp(io_clamp), .ret_n(ret_n), .stby_n(stby_n),
    .core_clk_en(core_clk_en), .bank_on(bank_on));

  function automatic logic [VW-1:0] obs();
    return {fault, finished, dom_rst, core_rst, bus_rst, core_hold, ref_clk_en,
            hs_on, ldo_bypass, mem_clamp, wl_clamp, io_clamp, ret_n, stby_n,
            core_clk_en, bank_on};
  endfunction

  task automatic check(logic [VW-1:0] e, string tag, int m);
    checks++;
    if (obs() !== e) begin
      fails++;
      $display("FAIL %s step %0d actual=%h expected=%h", tag, m, obs(), e);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  endtask

  task automatic idle_hold(logic [VW-1:0] e);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(e, "R11 idle", i);
    end
  endtask

  // returns 1 when the walk is expected to succeed
  task automatic run_up(int w, bit inj, bit both, output bit ok);
    logic [VW-1:0] e;
    int k, a, b0, wl, fin;
    string tag;
    ok = (w <= PM*G - 1);
    k = (w + G) / G;
    a = 2 + k*G;
    b0 = a + S + 3;
    wl = b0 + NB*S;
    fin = ok ? wl + 4 : 2 + PM*G;
    @(negedge clk);
    e = obs();
    clk_off = 1'b1; up_req = 1'b1; down_req = both;
    for (int m = 1; m <= fin; m++) begin
      @(negedge clk);
      if (m == 1 || m == 11) begin up_req = 1'b0; down_req = 1'b0; end
      clk_off = (m >= 2 + w) ? 1'b0 : 1'b1;
      if (m == 1) begin e[FIN] = 0; e[FLT] = 0; end
      if (m == 2) begin
        e[CRST] = 1; e[BRST] = 1; e[HOLD] = 1; e[DRST] = 0; e[REF] = 1;
      end
      if (ok) begin
        if (m == a) e[HS] = 1;
        if (m == a + S) e[BYP] = 1;
        if (m == a + S + 1) e[MCL] = 0;
        if (m == a + S + 2) begin e[RET] = 1; e[STBY] = 1; end
        for (int j = 0; j < NB; j++) if (m == b0 + j*S) e[NB-1-j] = 1;
        if (m == wl) e[WLC] = 0;
        if (m == wl + 1) e[IOC] = 0;
        if (m == wl + 2) e[CRST] = 0;
        if (m == wl + 3) e[CCLK] = 1;
        if (m == wl + 4) begin e[HOLD] = 0; e[FIN] = 1; end
      end else if (m == fin) e[FLT] = 1;
      if (inj) tag = "R11 busy up";
      else if (both && m <= 2) tag = "R11 both";
      else if (m < 2) tag = "R12";
      else if (m == 2) tag = "R2";
      else if (!ok || m <= a) tag = "R3";
      else if (m <= a + S) tag = "R4";
      else if (m < b0) tag = "R5";
      else if (m < wl) tag = "R6";
      else tag = "R7";
      check(e, tag, m);
      if (inj && m == 10) begin up_req = 1'b1; down_req = 1'b1; end
    end
    idle_hold(e);
  endtask

  task automatic run_down(int w, bit inj, output bit ok);
    logic [VW-1:0] e;
    int k, h, fin;
    string tag;
    ok = (w <= PM*G - 1);
    k = (w + G) / G;
    h = 7 + NB*B;
    fin = ok ? h + k*G : h + PM*G;
    @(negedge clk);
    e = obs();
    hs_ack = 1'b1; down_req = 1'b1;
    for (int m = 1; m <= fin; m++) begin
      @(negedge clk);
      if (m == 1 || m == 11) begin up_req = 1'b0; down_req = 1'b0; end
      hs_ack = (m >= h + w) ? 1'b0 : 1'b1;
      if (m == 1) begin e[FIN] = 0; e[FLT] = 0; end
      if (m == 2) e[CCLK] = 0;
      if (m == 3) e[IOC] = 1;
      if (m == 4) e[STBY] = 0;
      if (m == 5) e[RET] = 0;
      for (int j = 0; j < NB; j++) if (m == 6 + j*B) e[j] = 0;
      if (m == 6 + NB*B) e[MCL] = 1;
      if (m == h) e[HS] = 0;
      if (m == fin) begin
        if (ok) begin e[DRST] = 1; e[CRST] = 1; e[FIN] = 1; end
        else e[FLT] = 1;
      end
      if (inj) tag = "R11 busy down";
      else if (m < 6) tag = "R8";
      else if (m < 6 + NB*B) tag = "R9";
      else tag = "R10";
      check(e, tag, m);
      if (inj && m == 10) begin up_req = 1'b1; down_req = 1'b1; end
    end
    idle_hold(e);
  endtask

  initial begin
    logic [VW-1:0] rv;
    rv = '0;
    rv[DRST] = 1; rv[CRST] = 1; rv[BRST] = 1; rv[HOLD] = 1;
    rv[MCL] = 1; rv[WLC] = 1; rv[IOC] = 1;
    repeat (3) @(negedge clk);
    check(rv, "R1 in reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rv, "R1 after reset", 1);
    for (int w = 0; w <= PM*G + 1; w++) begin
      bit ok;
      run_up(w, w == 1, w == 2, ok);
      if (!ok) run_up(0, 0, 0, ok);
      run_down(w, w == 3, ok);
    end
    report();
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
    report();
  end
endmodule